// File: doc/BRIEF.md
# Requester-to-Domain Context Resolver

This block turns the 16-bit requester identifier of an incoming DMA request into the domain that request belongs to. It walks two tables held in memory. The first is a 4 KB table of 256 bus-level entries at a configured base address. The second is a per-bus table of 256 device-level entries. The block reads one 16-byte entry from each table over a simple read request/response port. When both entries are marked present, it reports the domain identifier, the translation type and the address width. When either entry is marked absent, it reports a translation fault instead.

Lookups run one at a time. A request is taken only while `req_ready` is high. Every lookup ends with a single-cycle `done` pulse. That pulse carries either a success result or a fault record, which holds the requester identifier and the table level that blocked the request. An alternate routing mode reinterprets the low byte of the identifier as a single 8-bit function number. In that mode the index into the device-level table does not change.

Top module: `dev_domain_resolver`

## Requirements
- R1: After a synchronous reset, `done`, `ok`, `fault` and `mem_req_valid` are low and `req_ready` is high.
- R2: The bus-level read address is `{root_base[ADDR_W-1:12], rid[15:8], 4'h0}`. Bits 11:0 of `root_base` are ignored.
- R3: In a bus-level entry, bit 0 is the present flag and bits ADDR_W-1:12 are the device-table page. The device-level read address is `{page, rid[7:0], 4'h0}`, and entry bits 11:1 are ignored.
- R4: In a device-level entry, bit 0 is the present flag, bits 3:2 are the translation type, bits 66:64 are the address width and bits 87:72 are the domain identifier.
- R5: An absent bus-level entry ends the lookup with `fault` high and `fault_level` = 1, and no device-level read is issued.
- R6: An absent device-level entry ends the lookup with `fault` high and `fault_level` = 2.
- R7: A lookup that finds both entries present raises `done` and `ok` for exactly one cycle, with `dom_id`, `xlat_type` and `addr_width` taken from the device-level entry.
- R8: On every `done`, exactly one of `ok` and `fault` is high. On a fault, `fault_rid` equals the identifier of the request.
- R9: A request is accepted only while `req_ready` is high, and `req_ready` stays low from acceptance until `done`. Requests presented during a lookup are ignored.
- R10: With `req_alt_route` low, `res_dev` = rid[7:3] and `res_func` = rid[2:0]. With it high, `res_dev` = 0 and `res_func` = rid[7:0].
- R11: Each memory read is a single-cycle `mem_req_valid` pulse. Only one read is outstanding at a time.
- R12: The block waits any number of cycles for `mem_rsp_valid`. `done` only follows a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_rid | input | 16 | Requester identifier (bus, device, function) |
| req_alt_route | input | 1 | Treat the low byte as one 8-bit function number |
| req_ready | output | 1 | Block is idle and can take a request |
| root_base | input | ADDR_W | Base address of the bus-level table |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | ADDR_W | Read address of a 16-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Entry contents |
| done | output | 1 | Lookup finished (one cycle) |
| ok | output | 1 | Lookup succeeded |
| fault | output | 1 | Lookup blocked |
| fault_level | output | 2 | 1 = bus-level entry absent, 2 = device-level entry absent |
| fault_rid | output | 16 | Identifier of the faulting request |
| dom_id | output | DID_W | Domain identifier |
| xlat_type | output | 2 | Translation type |
| addr_width | output | 3 | Address width code |
| res_dev | output | 5 | Resolved device number |
| res_func | output | 8 | Resolved function number |

## Verification
The assertions check the following on every cycle: the shape of the memory handshake, the single-cycle `done` and `ok`/`fault` pulses, that `ok` and `fault` never rise together, the legal fault levels, and that no request is taken while busy. Several behaviours can only be shown by the bench's scenarios, because they depend on table contents the bench serves. These are the correct address arithmetic at both levels, that low pointer and base bits are ignored, the placement of the entry fields, the split between the two routing modes, and the fact that a bus-level fault skips the second read.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int RID_W      = 16;
  localparam int IDX_W      = 8;
  localparam int DEV_W      = 5;
  localparam int FN_W       = 3;
  localparam int PAGE_SH    = 12;
  localparam int ENTRY_SH   = 4;
  localparam int TT_W       = 2;
  localparam int AW_W       = 3;
  localparam int CTX_TT_LSB = 2;
  localparam int CTX_AW_LSB = 64;
  localparam int CTX_DID_LSB = 72;

  localparam logic [1:0] LVL_ROOT = 2'd1;
  localparam logic [1:0] LVL_CTX  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROOT_REQ,
    ST_ROOT_WAIT,
    ST_CTX_WAIT
  } walk_st_e;
endpackage

// File: rtl/rid_split.sv
module rid_split
  import rsv_pkg::*;
(
  input  logic [RID_W-1:0] rid,
  input  logic             alt_route,
  output logic [IDX_W-1:0] bus_idx,
  output logic [IDX_W-1:0] devfn_idx,
  output logic [DEV_W-1:0] dev_num,
  output logic [IDX_W-1:0] func_num
);
  // The index into the device table is the low byte in both routing modes.
  assign bus_idx   = rid[RID_W-1 -: IDX_W];
  assign devfn_idx = rid[IDX_W-1:0];

  always_comb begin
    if (alt_route) begin
      dev_num  = '0;
      func_num = rid[IDX_W-1:0];
    end else begin
      dev_num  = rid[FN_W +: DEV_W];
      func_num = {{(IDX_W-FN_W){1'b0}}, rid[FN_W-1:0]};
    end
  end
endmodule

// File: rtl/entry_decode.sv
module entry_decode
  import rsv_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 128,
  parameter int DID_W  = 16
) (
  input  logic [DATA_W-1:0]         data,
  output logic                      present,
  output logic [ADDR_W-PAGE_SH-1:0] ptr_page,
  output logic [TT_W-1:0]           tt,
  output logic [AW_W-1:0]           aw,
  output logic [DID_W-1:0]          did
);
  logic unused_bits;

  // Bit 0 is the present flag in both kinds of entry.
  assign present  = data[0];
  assign ptr_page = data[ADDR_W-1:PAGE_SH];
  assign tt       = data[CTX_TT_LSB +: TT_W];
  assign aw       = data[CTX_AW_LSB +: AW_W];
  assign did      = data[CTX_DID_LSB +: DID_W];
  assign unused_bits = ^data;
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import rsv_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DID_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [RID_W-1:0]          req_rid,
  input  logic                      req_alt_route,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         root_base,
  output logic [RID_W-1:0]          cur_rid,
  output logic                      cur_alt,
  input  logic [IDX_W-1:0]          bus_idx,
  input  logic [IDX_W-1:0]          devfn_idx,
  input  logic [DEV_W-1:0]          dev_num,
  input  logic [IDX_W-1:0]          func_num,
  input  logic                      ent_present,
  input  logic [ADDR_W-PAGE_SH-1:0] ent_page,
  input  logic [TT_W-1:0]           ent_tt,
  input  logic [AW_W-1:0]           ent_aw,
  input  logic [DID_W-1:0]          ent_did,
  output logic                      mem_req_valid,
  output logic [ADDR_W-1:0]         mem_req_addr,
  input  logic                      mem_rsp_valid,
  output logic                      done,
  output logic                      ok,
  output logic                      fault,
  output logic [1:0]                fault_level,
  output logic [RID_W-1:0]          fault_rid,
  output logic [DID_W-1:0]          dom_id,
  output logic [TT_W-1:0]           xlat_type,
  output logic [AW_W-1:0]           addr_width,
  output logic [DEV_W-1:0]          res_dev,
  output logic [IDX_W-1:0]          res_func
);
  walk_st_e state;
  logic     unused_base;

  assign req_ready   = (state == ST_IDLE);
  assign unused_base = ^root_base[PAGE_SH-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cur_rid       <= '0;
      cur_alt       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done          <= 1'b0;
      ok            <= 1'b0;
      fault         <= 1'b0;
      fault_level   <= '0;
      fault_rid     <= '0;
      dom_id        <= '0;
      xlat_type     <= '0;
      addr_width    <= '0;
      res_dev       <= '0;
      res_func      <= '0;
    end else begin
      done          <= 1'b0;
      ok            <= 1'b0;
      fault         <= 1'b0;
      mem_req_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_rid <= req_rid;
            cur_alt <= req_alt_route;
            state   <= ST_ROOT_REQ;
          end
        end
        ST_ROOT_REQ: begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= {root_base[ADDR_W-1:PAGE_SH], bus_idx,
                            {ENTRY_SH{1'b0}}};
          state         <= ST_ROOT_WAIT;
        end
        ST_ROOT_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_present) begin
              done        <= 1'b1;
              fault       <= 1'b1;
              fault_level <= LVL_ROOT;
              fault_rid   <= cur_rid;
              res_dev     <= dev_num;
              res_func    <= func_num;
              state       <= ST_IDLE;
            end else begin
              // Pointer bits below the page boundary are dropped here.
              mem_req_valid <= 1'b1;
              mem_req_addr  <= {ent_page, devfn_idx, {ENTRY_SH{1'b0}}};
              state         <= ST_CTX_WAIT;
            end
          end
        end
        ST_CTX_WAIT: begin
          if (mem_rsp_valid) begin
            done     <= 1'b1;
            res_dev  <= dev_num;
            res_func <= func_num;
            state    <= ST_IDLE;
            if (ent_present) begin
              ok         <= 1'b1;
              dom_id     <= ent_did;
              xlat_type  <= ent_tt;
              addr_width <= ent_aw;
            end else begin
              fault       <= 1'b1;
              fault_level <= LVL_CTX;
              fault_rid   <= cur_rid;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_rsp_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rsp_valid));
  p_fault_level_r5: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_level == LVL_ROOT || fault_level == LVL_CTX));
  p_ok_or_fault_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (ok != fault));
  p_busy_after_take_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/dev_domain_resolver.sv
module dev_domain_resolver
  import rsv_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 128,
  parameter int DID_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [15:0]       req_rid,
  input  logic              req_alt_route,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              ok,
  output logic              fault,
  output logic [1:0]        fault_level,
  output logic [15:0]       fault_rid,
  output logic [DID_W-1:0]  dom_id,
  output logic [1:0]        xlat_type,
  output logic [2:0]        addr_width,
  output logic [4:0]        res_dev,
  output logic [7:0]        res_func
);
  logic [RID_W-1:0]          cur_rid;
  logic                      cur_alt;
  logic [IDX_W-1:0]          bus_idx, devfn_idx, func_num;
  logic [DEV_W-1:0]          dev_num;
  logic                      ent_present;
  logic [ADDR_W-PAGE_SH-1:0] ent_page;
  logic [TT_W-1:0]           ent_tt;
  logic [AW_W-1:0]           ent_aw;
  logic [DID_W-1:0]          ent_did;

  rid_split u_split (
    .rid       (cur_rid),
    .alt_route (cur_alt),
    .bus_idx   (bus_idx),
    .devfn_idx (devfn_idx),
    .dev_num   (dev_num),
    .func_num  (func_num)
  );

  entry_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DID_W(DID_W)) u_dec (
    .data     (mem_rsp_data),
    .present  (ent_present),
    .ptr_page (ent_page),
    .tt       (ent_tt),
    .aw       (ent_aw),
    .did      (ent_did)
  );

  walk_ctrl #(.ADDR_W(ADDR_W), .DID_W(DID_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_rid       (req_rid),
    .req_alt_route (req_alt_route),
    .req_ready     (req_ready),
    .root_base     (root_base),
    .cur_rid       (cur_rid),
    .cur_alt       (cur_alt),
    .bus_idx       (bus_idx),
    .devfn_idx     (devfn_idx),
    .dev_num       (dev_num),
    .func_num      (func_num),
    .ent_present   (ent_present),
    .ent_page      (ent_page),
    .ent_tt        (ent_tt),
    .ent_aw        (ent_aw),
    .ent_did       (ent_did),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .ok            (ok),
    .fault         (fault),
    .fault_level   (fault_level),
    .fault_rid     (fault_rid),
    .dom_id        (dom_id),
    .xlat_type     (xlat_type),
    .addr_width    (addr_width),
    .res_dev       (res_dev),
    .res_func      (res_func)
  );
endmodule

// File: tb/dev_domain_resolver_test.sv
`timescale 1ns/1ps
module dev_domain_resolver_test;
  localparam logic [47:0] BASE = 48'h00AB_CDE0_0777;

  typedef struct packed {
    logic [15:0] rid;
    logic        alt;
    logic        rp;
    logic        cp;
    logic [47:0] ptr;
    logic [1:0]  tt;
    logic [2:0]  aw;
    logic [15:0] did;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'h0312, 1'b0, 1'b1, 1'b1, 48'h0000_4567_8ABC, 2'd1, 3'd2, 16'h0042, 4'd1},
    '{16'hFFFF, 1'b0, 1'b1, 1'b1, 48'h7FFF_FFFF_F001, 2'd3, 3'd4, 16'hFFFF, 4'd3},
    '{16'h0000, 1'b1, 1'b1, 1'b1, 48'h0000_0000_1000, 2'd0, 3'd1, 16'h0001, 4'd5},
    '{16'h2A9D, 1'b0, 1'b0, 1'b1, 48'h0000_0009_9000, 2'd1, 3'd1, 16'h0BAD, 4'd2},
    '{16'h80F7, 1'b1, 1'b1, 1'b0, 48'h0000_0077_7FFF, 2'd2, 3'd2, 16'h0BAD, 4'd1},
    '{16'h5B28, 1'b1, 1'b1, 1'b1, 48'h0000_1111_2345, 2'd2, 3'd3, 16'h1234, 4'd4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_alt_route = 1'b0;
  logic [15:0] req_rid = '0;
  logic req_ready;
  logic mem_req_valid;
  logic [47:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [127:0] mem_rsp_data;
  logic done, ok, fault;
  logic [1:0] fault_level;
  logic [15:0] fault_rid, dom_id;
  logic [1:0] xlat_type;
  logic [2:0] addr_width;
  logic [4:0] res_dev;
  logic [7:0] res_func;

  always #2.5 clk = ~clk;

  dev_domain_resolver uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rid(req_rid),
    .req_alt_route(req_alt_route), .req_ready(req_ready), .root_base(BASE),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .ok(ok), .fault(fault), .fault_level(fault_level),
    .fault_rid(fault_rid), .dom_id(dom_id), .xlat_type(xlat_type),
    .addr_width(addr_width), .res_dev(res_dev), .res_func(res_func)
  );

  int checks = 0, fails = 0;
  vec_t cur = '0;
  int root_cnt = 0, ctx_cnt = 0, bad_cnt = 0, done_cnt = 0;

  function automatic logic [47:0] root_exp(vec_t v);
    return {BASE[47:12], v.rid[15:8], 4'h0};
  endfunction
  function automatic logic [47:0] ctx_exp(vec_t v);
    return {v.ptr[47:12], v.rid[7:0], 4'h0};
  endfunction
  function automatic logic [127:0] entry_at(logic [47:0] a, vec_t v);
    logic [127:0] r = '0;
    if (a == root_exp(v)) begin
      r[47:12] = v.ptr[47:12];
      r[11:1]  = 11'h5A5;
      r[0]     = v.rp;
    end else if (a == ctx_exp(v)) begin
      r[0]      = v.cp;
      r[3:2]    = v.tt;
      r[66:64]  = v.aw;
      r[87:72]  = v.did;
      r[127:120] = 8'hEE;
    end
    return r;
  endfunction

  // Memory model serving the two tables with per-vector latency.
  logic        pend = 1'b0;
  logic [47:0] paddr = '0;
  logic [3:0]  pcnt = '0;
  always @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (done) done_cnt <= done_cnt + 1;
      if (mem_req_valid) begin
        pend  <= 1'b1;
        paddr <= mem_req_addr;
        pcnt  <= cur.lat;
        if (mem_req_addr == root_exp(cur)) root_cnt <= root_cnt + 1;
        else if (mem_req_addr == ctx_exp(cur)) ctx_cnt <= ctx_cnt + 1;
        else bad_cnt <= bad_cnt + 1;
      end else if (pend) begin
        if (pcnt <= 4'd1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= entry_at(paddr, cur);
          pend <= 1'b0;
        end else pcnt <= pcnt - 4'd1;
      end
    end
  end

  task automatic check(input bit cond, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit inject);
    int r0, c0, b0, d0, w;
    cur = v;
    r0 = root_cnt; c0 = ctx_cnt; b0 = bad_cnt; d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_rid = v.rid; req_alt_route = v.alt;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      check(!req_ready, "R9 busy ready", 64'(req_ready), 0);
      req_valid = 1'b1; req_rid = 16'hDEAD; req_alt_route = ~v.alt;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 200) begin
      @(negedge clk);
      w++;
    end
    check(done, "R12 done seen (watchdog)", 64'(done), 1);
    if (!v.rp) begin
      check(fault && !ok, "R5 root fault", {ok, fault}, 2'b01);
      check(fault_level == 2'd1, "R5 level", 64'(fault_level), 1);
      check(fault_rid == v.rid, "R8 fault rid", 64'(fault_rid), 64'(v.rid));
      check(ctx_cnt == c0, "R5 no ctx read", 64'(ctx_cnt - c0), 0);
    end else if (!v.cp) begin
      check(fault && !ok, "R6 ctx fault", {ok, fault}, 2'b01);
      check(fault_level == 2'd2, "R6 level", 64'(fault_level), 2);
      check(fault_rid == v.rid, "R8 fault rid", 64'(fault_rid), 64'(v.rid));
      check(ctx_cnt == c0 + 1, "R3 ctx addr", 64'(ctx_cnt - c0), 1);
    end else begin
      check(ok && !fault, "R7 ok", {ok, fault}, 2'b10);
      check(dom_id == v.did, "R4 dom_id", 64'(dom_id), 64'(v.did));
      check(xlat_type == v.tt, "R4 xlat_type", 64'(xlat_type), 64'(v.tt));
      check(addr_width == v.aw, "R4 addr_width", 64'(addr_width), 64'(v.aw));
      check(ctx_cnt == c0 + 1, "R3 ctx addr", 64'(ctx_cnt - c0), 1);
      check(res_dev == (v.alt ? 5'd0 : v.rid[7:3]), "R10 res_dev",
            64'(res_dev), 64'(v.alt ? 5'd0 : v.rid[7:3]));
      check(res_func == (v.alt ? v.rid[7:0] : {5'd0, v.rid[2:0]}), "R10 res_func",
            64'(res_func), 64'(v.alt ? v.rid[7:0] : {5'd0, v.rid[2:0]}));
    end
    check(root_cnt == r0 + 1, "R2 root addr", 64'(root_cnt - r0), 1);
    check(bad_cnt == b0, "R11 stray reads", 64'(bad_cnt - b0), 0);
    @(negedge clk);
    check(!done, "R7 done one cycle", 64'(done), 0);
    repeat (8) @(negedge clk);
    check(done_cnt == d0 + 1, "R9 single done", 64'(done_cnt - d0), 1);
    check(req_ready, "R9 idle ready", 64'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !ok && !fault && !mem_req_valid, "R1 reset outputs",
          {done, ok, fault, mem_req_valid}, 0);
    check(req_ready, "R1 reset ready", 64'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
    // Directed: requests during a walk are ignored (R9), long latency (R12).
    run_vec('{16'h4C01, 1'b0, 1'b1, 1'b1, 48'h0000_2222_3FFF, 2'd3, 3'd5,
              16'h7E57, 4'd9}, 1'b1);
    run_vec('{16'hC3B6, 1'b1, 1'b0, 1'b0, 48'h0, 2'd0, 3'd0, 16'h0, 4'd7}, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule